// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a processor. It decides which handler the processor should run next. It has five request sources: two external lines, two timer overflows and one serial event. Each source has a fixed priority from 1 to 7, and level 0 means that no handler is running. A request is latched into a pending bit as soon as it is seen. When the request is granted, the block raises a one-cycle grant strobe together with the source index and that source's vector address. The processor reports the end of a handler with a one-cycle done strobe.

A mode input selects one of two disciplines. In sequential mode, a running handler blocks every new grant until it finishes. In nested mode, a request of strictly higher priority preempts the running handler. The preempted level is pushed onto a small stack of active levels. On every handler end, the previous level is popped. The block then re-arbitrates the held requests against that restored level before the preempted handler continues. If nothing outranks the restored level, a resume strobe reports the level the processor returns to.

The state machine has three states:
- `ST_BASE`: no handler is active.
- `ST_HANDLER`: a handler is running.
- `ST_RETURN`: a one-cycle state that follows each pop.

Its transitions are:
- base to handler: grant from idle.
- handler to handler: preemption, nested mode only.
- handler to return: done strobe.
- return to handler: a re-grant, or a resume to a preempted level.
- return to base: a resume to level 0.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A request pulse on `irq_req[i]` sets a pending bit that holds the request until it is granted, however long servicing is blocked. Pending bits are cleared only by their own grant or by reset.
- R2: A pending request is granted by a one-cycle `grant_vld` pulse. When the controller is in `ST_BASE`, the grant comes on the first clock edge after the edge that latched the request. The grant edge clears that pending bit, so one request pulse produces exactly one grant.
- R3: With each grant, `grant_idx` carries the source index and `grant_vec` carries 16'h0040 + 16'h0010 × index.
- R4: The source priorities are: index 0 → 2, index 1 → 4, index 2 → 5, index 3 → 2, index 4 → 3. `act_level` shows the priority of the running handler, or 0 at base. It takes the new level on the grant edge.
- R5: Among pending requests of equal top priority, the lowest index is granted first. A request of the same priority as the running handler never preempts it.
- R6: When `nest_mode` is 0, no grant is issued while a handler is running. After `hdl_done`, any pending request is granted before the return to base.
- R7: When `nest_mode` is 1, a pending request whose priority is strictly above `act_level` is granted on the next edge, and the current level is pushed onto the stack.
- R8: When `nest_mode` is 1, a request of lower priority than the running handler stays pending, and no grant occurs until the handler ends.
- R9: `hdl_done` in a handler pops the previous level into `act_level`. On the next edge, the controller either grants the best held request that outranks that level, or pulses `resume_vld` with `act_level` unchanged. It never does both in the same cycle.
- R10: `hdl_done` while no handler is running has no effect: there is no resume, no grant and no change of level.
- R11: Synchronous reset clears all pending bits, empties the stack, and returns to level 0 with grants enabled and `stk_ovf` low.
- R12: `stk_ovf` is set if a push meets a full stack. Its depth equals the number of sources, so with the default priorities it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nest_mode | input | 1 | 1 = nested preemption, 0 = sequential |
| irq_req | input | 5 | Request lines: index 0/1 external, 2/3 timer overflow, 4 serial |
| hdl_done | input | 1 | End-of-handler strobe from the processor |
| grant_vld | output | 1 | One-cycle handler entry strobe |
| grant_idx | output | 3 | Index of the granted source |
| grant_vec | output | 16 | Vector address of the granted source |
| resume_vld | output | 1 | One-cycle strobe: the processor resumes at `act_level` |
| act_level | output | 3 | Priority level now running (0 = base) |
| stk_ovf | output | 1 | Sticky stack overflow flag |

## Verification
From `ST_BASE`, a grant is due one edge after the edge that latches the request. A preemption in a handler is due on the same schedule. After `hdl_done`, the re-grant or the resume strobe is due on the second edge: the first edge pops the level, the second edge arbitrates. The bench drives every input on a falling edge, holds it for exactly one rising edge, and waits a further clock before sampling on a falling edge. Each check therefore looks at the cycle in which the result must be present. The bench sweeps every ordered pair of distinct sources in both modes and predicts preemption or holding from its own priority table. It also replays the 2-5-4 nesting order, a simultaneous equal-priority pair, a triple arrival, a done strobe at base, and a reset with a request held pending.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_BASE    = 2'd0,
        ST_HANDLER = 2'd1,
        ST_RETURN  = 2'd2
    } nic_state_e;

endpackage

// File: rtl/nic_pend.sv
// Pending request latch: sticky set from the lines, cleared by the grant.
module nic_pend #(
    parameter int NSRC = 5,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic            clr_vld,
    input  logic [IW-1:0]   clr_idx,
    output logic [NSRC-1:0] pend
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_vld) begin
            clr_mask = NSRC'(1) << clr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | req) & ~clr_mask;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/nic_arb.sv
// Fixed-priority arbiter: highest level wins, lowest index breaks ties.
module nic_arb #(
    parameter int                  NSRC     = 5,
    parameter int                  PW       = 3,
    parameter int                  IW       = 3,
    parameter logic [NSRC*PW-1:0]  SRC_PRIO = '0
) (
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [IW-1:0]   best_idx,
    output logic [PW-1:0]   best_prio
);

    logic [PW-1:0] prio_arr [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_prio
        assign prio_arr[g] = SRC_PRIO[g*PW +: PW];
    end

    always_comb begin
        any       = |pend;
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (prio_arr[i] > best_prio)) begin
                best_prio = prio_arr[i];
                best_idx  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/nic_stack.sv
// Stack of preempted levels with a sticky overflow flag.
module nic_stack #(
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [PW-1:0] push_lvl,
    input  logic          pop,
    output logic [PW-1:0] top,
    output logic          empty,
    output logic          ovf
);

    localparam int DW = $clog2(DEPTH + 1);

    logic [PW-1:0] mem [DEPTH];
    logic [DW-1:0] depth_q;
    logic          ovf_q;
    logic          full;

    assign empty = (depth_q == '0);
    assign full  = (depth_q == DW'(DEPTH));

    always_comb begin
        top = '0;
        if (!empty) begin
            top = mem[depth_q - 1'b1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            ovf_q   <= 1'b0;
        end else if (pop) begin
            if (!empty) begin
                depth_q <= depth_q - 1'b1;
            end
        end else if (push) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                mem[depth_q] <= push_lvl;
                depth_q      <= depth_q + 1'b1;
            end
        end
    end

    assign ovf = ovf_q;

endmodule

// File: rtl/nic_fsm.sv
// Sequencer: grant, preemption, return and resume.
module nic_fsm
    import nic_pkg::*;
#(
    parameter int             PW         = 3,
    parameter int             IW         = 3,
    parameter int             VW         = 16,
    parameter logic [VW-1:0]  VEC_BASE   = 16'h0040,
    parameter logic [VW-1:0]  VEC_STRIDE = 16'h0010
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nest_mode,
    input  logic          hdl_done,
    input  logic          any,
    input  logic [IW-1:0] best_idx,
    input  logic [PW-1:0] best_prio,
    input  logic [PW-1:0] stk_top,
    input  logic          stk_empty,
    output logic          push,
    output logic [PW-1:0] push_lvl,
    output logic          pop,
    output logic          grant_vld,
    output logic [IW-1:0] grant_idx,
    output logic [VW-1:0] grant_vec,
    output logic          resume_vld,
    output logic [PW-1:0] act_level
);

    nic_state_e    state_q, state_d;
    logic          grant_ok;
    logic          outranks;
    logic [PW-1:0] lvl_q;

    assign outranks = any && (best_prio > lvl_q);

    // Grant and pop decisions for the current state.
    always_comb begin
        grant_ok = 1'b0;
        pop      = 1'b0;
        unique case (state_q)
            ST_BASE: begin
                grant_ok = any;
            end
            ST_HANDLER: begin
                if (hdl_done) begin
                    pop = 1'b1;
                end else begin
                    grant_ok = nest_mode && outranks;
                end
            end
            ST_RETURN: begin
                grant_ok = nest_mode ? outranks : (any && stk_empty);
            end
            default: begin
                grant_ok = 1'b0;
            end
        endcase
    end

    assign push     = grant_ok;
    assign push_lvl = lvl_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BASE: begin
                if (grant_ok) state_d = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (pop) state_d = ST_RETURN;
            end
            ST_RETURN: begin
                if (grant_ok)       state_d = ST_HANDLER;
                else if (stk_empty) state_d = ST_BASE;
                else                state_d = ST_HANDLER;
            end
            default: begin
                state_d = ST_BASE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BASE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_vld  <= 1'b0;
            grant_idx  <= '0;
            grant_vec  <= '0;
            resume_vld <= 1'b0;
            lvl_q      <= '0;
        end else begin
            grant_vld  <= grant_ok;
            resume_vld <= (state_q == ST_RETURN) && !grant_ok;
            if (grant_ok) begin
                grant_idx <= best_idx;
                grant_vec <= VEC_BASE + (VW'(best_idx) * VEC_STRIDE);
                lvl_q     <= best_prio;
            end else if (pop) begin
                lvl_q <= stk_top;
            end
        end
    end

    assign act_level = lvl_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int                 NSRC       = 5,
    parameter int                 PW         = 3,
    parameter int                 VW         = 16,
    parameter logic [NSRC*PW-1:0] SRC_PRIO   = {3'd3, 3'd2, 3'd5, 3'd4, 3'd2},
    parameter logic [VW-1:0]      VEC_BASE   = 16'h0040,
    parameter logic [VW-1:0]      VEC_STRIDE = 16'h0010,
    localparam int                IW         = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            nest_mode,
    input  logic [NSRC-1:0] irq_req,
    input  logic            hdl_done,
    output logic            grant_vld,
    output logic [IW-1:0]   grant_idx,
    output logic [VW-1:0]   grant_vec,
    output logic            resume_vld,
    output logic [PW-1:0]   act_level,
    output logic            stk_ovf
);

    logic [NSRC-1:0] pend;
    logic            any;
    logic [IW-1:0]   best_idx;
    logic [PW-1:0]   best_prio;
    logic            push;
    logic            pop;
    logic [PW-1:0]   push_lvl;
    logic [PW-1:0]   stk_top;
    logic            stk_empty;

    nic_pend #(.NSRC(NSRC), .IW(IW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .clr_vld (push),
        .clr_idx (best_idx),
        .pend    (pend)
    );

    nic_arb #(.NSRC(NSRC), .PW(PW), .IW(IW), .SRC_PRIO(SRC_PRIO)) u_arb (
        .pend      (pend),
        .any       (any),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    nic_stack #(.DEPTH(NSRC), .PW(PW)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_lvl (push_lvl),
        .pop      (pop),
        .top      (stk_top),
        .empty    (stk_empty),
        .ovf      (stk_ovf)
    );

    nic_fsm #(
        .PW(PW), .IW(IW), .VW(VW),
        .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .nest_mode  (nest_mode),
        .hdl_done   (hdl_done),
        .any        (any),
        .best_idx   (best_idx),
        .best_prio  (best_prio),
        .stk_top    (stk_top),
        .stk_empty  (stk_empty),
        .push       (push),
        .push_lvl   (push_lvl),
        .pop        (pop),
        .grant_vld  (grant_vld),
        .grant_idx  (grant_idx),
        .grant_vec  (grant_vec),
        .resume_vld (resume_vld),
        .act_level  (act_level)
    );

endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
    parameter int                 NSRC       = 5,
    parameter int                 PW         = 3,
    parameter int                 VW         = 16,
    parameter int                 IW         = 3,
    parameter logic [NSRC*PW-1:0] SRC_PRIO   = '0,
    parameter logic [VW-1:0]      VEC_BASE   = '0,
    parameter logic [VW-1:0]      VEC_STRIDE = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          nest_mode,
    input logic          grant_vld,
    input logic [IW-1:0] grant_idx,
    input logic [VW-1:0] grant_vec,
    input logic          resume_vld,
    input logic [PW-1:0] act_level,
    input logic          stk_ovf
);

    // R3
    vec_map_chk: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> (grant_vec == VEC_BASE + VW'(grant_idx) * VEC_STRIDE));

    // R4
    grant_level_chk: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> (act_level == SRC_PRIO[grant_idx*PW +: PW]));

    // R7
    strictly_higher_chk: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> (act_level > $past(act_level)));

    // R6
    seq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && !nest_mode && !$past(nest_mode)) |-> ($past(act_level) == '0));

    // R9
    grant_resume_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant_vld && resume_vld));

    // R9
    resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resume_vld |=> !resume_vld);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !stk_ovf);

endmodule

bind nest_irq_ctrl nic_chk #(
    .NSRC(NSRC), .PW(PW), .VW(VW), .IW(IW),
    .SRC_PRIO(SRC_PRIO), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .nest_mode  (nest_mode),
    .grant_vld  (grant_vld),
    .grant_idx  (grant_idx),
    .grant_vec  (grant_vec),
    .resume_vld (resume_vld),
    .act_level  (act_level),
    .stk_ovf    (stk_ovf)
);

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nest_mode = 1'b1;
    logic [4:0]  irq_req = '0;
    logic        hdl_done = 1'b0;
    logic        grant_vld;
    logic [2:0]  grant_idx;
    logic [15:0] grant_vec;
    logic        resume_vld;
    logic [2:0]  act_level;
    logic        stk_ovf;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .nest_mode  (nest_mode),
        .irq_req    (irq_req),
        .hdl_done   (hdl_done),
        .grant_vld  (grant_vld),
        .grant_idx  (grant_idx),
        .grant_vec  (grant_vec),
        .resume_vld (resume_vld),
        .act_level  (act_level),
        .stk_ovf    (stk_ovf)
    );

    function automatic int prio_of(int i);
        case (i)
            0: return 2;
            1: return 4;
            2: return 5;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [15:0] vec_of(int i);
        return 16'h0040 + 16'(i * 16);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_req(input logic [4:0] m);
        @(negedge clk); irq_req = m;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk); hdl_done = 1'b1;
        @(negedge clk); hdl_done = 1'b0;
    endtask

    // Compare all observable outputs against the expectation.
    task automatic expect_out(input string tag, input logic gv, input int idx,
                              input logic rv, input int lvl);
        logic ok;
        ok = (grant_vld == gv) && (resume_vld == rv) && (act_level == 3'(lvl))
             && (stk_ovf == 1'b0);
        if (gv) ok = ok && (grant_idx == 3'(idx)) && (grant_vec == vec_of(idx));
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got gv=%0b idx=%0d vec=%h rv=%0b lvl=%0d ovf=%0b exp gv=%0b idx=%0d vec=%h rv=%0b lvl=%0d ovf=0",
                     tag, grant_vld, grant_idx, grant_vec, resume_vld, act_level, stk_ovf,
                     gv, idx, vec_of(idx), rv, lvl);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R11 reset state
        expect_out("R11 reset state", 0, 0, 0, 0);

        // R10 done at base is ignored
        pulse_done(); step();
        expect_out("R10 done at base", 0, 0, 0, 0);
        step();
        expect_out("R10 done at base later", 0, 0, 0, 0);

        // Pair sweep in both modes: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int m = 0; m < 2; m++) begin
            nest_mode = (m == 1);
            for (int a = 0; a < 5; a++) begin
                for (int b = 0; b < 5; b++) begin
                    if (a != b) begin
                        int pa, pb;
                        pa = prio_of(a);
                        pb = prio_of(b);
                        pulse_req(5'(1 << a)); step();
                        expect_out("R2 R3 R4 first grant", 1, a, 0, pa);
                        pulse_req(5'(1 << b)); step();
                        if (m == 1 && pb > pa) begin
                            expect_out("R7 preempt", 1, b, 0, pb);
                            pulse_done(); step();
                            expect_out("R9 resume preempted", 0, 0, 1, pa);
                            pulse_done(); step();
                            expect_out("R9 resume base", 0, 0, 1, 0);
                        end else begin
                            expect_out(m == 1 ? "R8 R5 held" : "R6 blocked", 0, 0, 0, pa);
                            pulse_done(); step();
                            expect_out("R1 R6 R9 held request granted", 1, b, 0, pb);
                            pulse_done(); step();
                            expect_out("R9 resume base after held", 0, 0, 1, 0);
                        end
                        step();
                        expect_out("R2 single grant", 0, 0, 0, 0);
                    end
                end
            end
        end

        // Nesting order 2, 5, 4: R7 R8 R9
        nest_mode = 1'b1;
        pulse_req(5'b00001); step();
        expect_out("R7 order lvl2 start", 1, 0, 0, 2);
        pulse_req(5'b00100); step();
        expect_out("R7 order lvl5 preempts", 1, 2, 0, 5);
        pulse_req(5'b00010); step();
        expect_out("R8 order lvl4 held", 0, 0, 0, 5);
        pulse_done(); step();
        expect_out("R9 order lvl4 before lvl2 resumes", 1, 1, 0, 4);
        pulse_done(); step();
        expect_out("R9 order lvl2 resumes", 0, 0, 1, 2);
        pulse_done(); step();
        expect_out("R9 order base", 0, 0, 1, 0);

        // R5 simultaneous equal priority: index 0 before index 3
        pulse_req(5'b01001); step();
        expect_out("R5 tie lowest index", 1, 0, 0, 2);
        step();
        expect_out("R5 equal no preempt", 0, 0, 0, 2);
        pulse_done(); step();
        expect_out("R5 tie second", 1, 3, 0, 2);
        pulse_done(); step();
        expect_out("R5 tie base", 0, 0, 1, 0);

        // R4 triple arrival: highest priority first
        pulse_req(5'b10011); step();
        expect_out("R4 triple top", 1, 1, 0, 4);
        pulse_done(); step();
        expect_out("R4 triple second", 1, 4, 0, 3);
        pulse_done(); step();
        expect_out("R4 triple third", 1, 0, 0, 2);
        pulse_done(); step();
        expect_out("R4 triple base", 0, 0, 1, 0);

        // R11 reset clears pending and level
        nest_mode = 1'b0;
        pulse_req(5'b00001); step();
        expect_out("R11 pre-reset grant", 1, 0, 0, 2);
        pulse_req(5'b00100); step();
        expect_out("R11 pre-reset blocked", 0, 0, 0, 2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        step();
        expect_out("R11 after reset", 0, 0, 0, 0);
        step();
        expect_out("R11 pending cleared", 0, 0, 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule